// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single register transactions against a PHY over a two-wire serial management link. The link has a management clock, an output data line with its own output enable, and a separate input data line. A requester hands over one transaction at a time: a write flag, a 5-bit register number and, for writes, a 16-bit value. The block then clocks out a complete frame of fixed-length bit slots and returns to idle.

Each frame has 64 slots. They are, in order: a long run of driven ones for synchronisation, a start pattern, a two-bit operation code, a 5-bit PHY address that is always zero, and the 5-bit register number. A read then releases the line for one turnaround slot, samples sixteen data slots and adds one released closing slot. A write releases the line for two slots and then drives sixteen data bits. In every slot the data is placed while the management clock is low and the input is sampled while it is high. The management clock half-period is a parameter given in system clock cycles.

After the last slot the block holds every link output low for one more half-period, pulses a done flag for one cycle and shows ready again. Read data is delivered on a response bus that holds its value until a later read completes.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `req_ready` is 1 and `mdc`, `mdo`, `mdo_oe` and `rsp_done` are all 0.
- R2: The first 32 slots of every frame drive `mdo`=1 with `mdo_oe`=1.
- R3: Slots 32 and 33 drive 0 and then 1. Slots 34 and 35 carry the operation: 1 then 0 for a read (`req_write`=0), 0 then 1 for a write (`req_write`=1). All four are driven with `mdo_oe`=1.
- R4: Slots 36 to 40 drive five zeros, the PHY address. Slots 41 to 45 drive `req_reg` msb first. All ten are driven with `mdo_oe`=1.
- R5: In a read, slots 46 to 63 have `mdo_oe`=0 and `mdo`=0. `mdo` is never 1 while `mdo_oe` is 0.
- R6: For a read, `rsp_rdata` is built msb first from `mdi` as sampled in the high phases of slots 47 to 62 only. `mdi` in any other slot has no effect on it.
- R7: Every frame has exactly 64 rising edges of `mdc`.
- R8: `rsp_done` is high for exactly one cycle per frame. It rises 129 x `HALF_CYC` cycles after the clock edge that accepts the request, and `req_ready` returns to 1 in the same cycle.
- R9: Between the last slot and the next accepted request, `mdc`, `mdo` and `mdo_oe` stay 0.
- R10: In a write, slots 46 and 47 have `mdo_oe`=0. Slots 48 to 63 drive `req_wdata` msb first with `mdo_oe`=1.
- R11: A write frame leaves `rsp_rdata` at the value of the most recent read.
- R12: A request is accepted only while `req_ready` is 1. A `req_valid` raised during a frame changes neither that frame nor what follows it.
- R13: Each high phase of `mdc` lasts `HALF_CYC` system clock cycles, and `mdo` and `mdo_oe` do not change while `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 for a write transaction, 0 for a read |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Value to write |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_done | output | 1 | One-cycle pulse when a frame finishes |
| rsp_rdata | output | 16 | Data from the most recent read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_oe | output | 1 | Output enable for the data line |
| mdi | input | 1 | Management data in |

## Verification
The PHY model drives ones on `mdi` in every slot outside the read data window. A design that samples one slot early or late, or that keeps the turnaround or closing slot, therefore returns a shifted or corrupted word. Writes are interleaved with reads to catch a design that gives writes a single turnaround slot, which would misplace all sixteen data bits, or that overwrites the held read data when a write completes. A request raised in the middle of a frame would otherwise corrupt the register field or start a second frame, so the bench checks both the recorded slots and a quiet period after done. The latency and high-phase counts expose any off-by-one in the half-period counter or a missing idle tail.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } mdio_state_e;

  localparam int PHY_ADDR_W = 5;

  // slots: sync, start(2), op(2), phy, reg, turnaround(2 total budget), data
  function automatic int frame_len(input int pre_len, input int reg_w, input int data_w);
    return pre_len + 4 + PHY_ADDR_W + reg_w + 2 + data_w;
  endfunction

endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign phase_end = run && (cnt_q == CW'(HALF_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || phase_end) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_slot_encoder.sv
module mdio_slot_encoder #(
  parameter int PRE_LEN = 32,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int SLOT_W  = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              is_write,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [DATA_W-1:0] wdata,
  output logic              drive_en,
  output logic              drive_bit,
  output logic              capture
);
  localparam int START_AT = PRE_LEN;
  localparam int OP_AT    = START_AT + 2;
  localparam int PHY_AT   = OP_AT + 2;
  localparam int REG_AT   = PHY_AT + mdio_pkg::PHY_ADDR_W;
  localparam int TA_AT    = REG_AT + REG_W;
  localparam int RD_IN_AT = TA_AT + 1;
  localparam int WR_DT_AT = TA_AT + 2;
  localparam int RIW      = (REG_W > 1) ? $clog2(REG_W) : 1;
  localparam int DIW      = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  int           s;
  logic [RIW-1:0] ridx;
  logic [DIW-1:0] didx;

  always_comb begin
    s         = int'(slot);
    ridx      = RIW'(REG_W - 1 - (s - REG_AT));
    didx      = DIW'(DATA_W - 1 - (s - WR_DT_AT));
    drive_en  = 1'b0;
    drive_bit = 1'b0;
    capture   = 1'b0;
    if (s < START_AT) begin
      drive_en  = 1'b1;
      drive_bit = 1'b1;
    end else if (s < OP_AT) begin
      drive_en  = 1'b1;
      drive_bit = (s == START_AT + 1);
    end else if (s < PHY_AT) begin
      drive_en  = 1'b1;
      drive_bit = (s == OP_AT) ? !is_write : is_write;
    end else if (s < REG_AT) begin
      drive_en  = 1'b1;
    end else if (s < TA_AT) begin
      drive_en  = 1'b1;
      drive_bit = reg_num[ridx];
    end else if (is_write) begin
      if (s >= WR_DT_AT) begin
        drive_en  = 1'b1;
        drive_bit = wdata[didx];
      end
    end else begin
      capture = (s >= RD_IN_AT) && (s < RD_IN_AT + DATA_W);
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int HALF_CYC = 2,
  parameter int PRE_LEN  = 32,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_oe,
  input  logic              mdi
);
  import mdio_pkg::*;

  localparam int FRAME_SLOTS = frame_len(PRE_LEN, REG_W, DATA_W);
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);

  logic              rst_i_n;
  mdio_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              wr_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d;
  logic              accept, phase_end, running, in_slot;
  logic              drive_en, drive_bit, capture;

  mdio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign running = (state_q != ST_IDLE);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign in_slot = (state_q == ST_LOW) || (state_q == ST_HIGH);

  mdio_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .run       (running),
    .phase_end (phase_end)
  );

  mdio_slot_encoder #(
    .PRE_LEN (PRE_LEN),
    .REG_W   (REG_W),
    .DATA_W  (DATA_W),
    .SLOT_W  (SLOT_W)
  ) u_enc (
    .slot      (slot_q),
    .is_write  (wr_q),
    .reg_num   (reg_q),
    .wdata     (wdata_q),
    .drive_en  (drive_en),
    .drive_bit (drive_bit),
    .capture   (capture)
  );

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    shift_d = shift_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_LOW;
          slot_d  = '0;
        end
      end
      ST_LOW: begin
        if (phase_end) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (phase_end) begin
          if (capture) shift_d = {shift_q[DATA_W-2:0], mdi};
          if (slot_q == SLOT_W'(FRAME_SLOTS - 1)) begin
            state_d = ST_TAIL;
          end else begin
            slot_d  = slot_q + 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      default: begin
        if (phase_end) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (!wr_q) rdata_d = shift_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      shift_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      shift_q <= shift_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  // request bank, loaded only on accept
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_q    <= 1'b0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      reg_q   <= req_reg;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign mdc       = (state_q == ST_HIGH);
  assign mdo_oe    = in_slot && drive_en;
  assign mdo       = in_slot && drive_en && drive_bit;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic mdc,
  input logic mdo,
  input logic mdo_oe
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && !mdo && !mdo_oe));

  assert_mdo_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdo |-> mdo_oe);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_done_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_stable_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_oe)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mdc       (mdc),
  .mdo       (mdo),
  .mdo_oe    (mdo_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_done, mdc, mdo, mdo_oe;
  logic [15:0] rsp_rdata;
  logic        mdi;

  int n_checks = 0;
  int n_fail   = 0;

  logic        rec_mdo [0:127];
  logic        rec_oe  [0:127];
  int          slot_n;
  logic [15:0] phy_word;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdo(mdo),
    .mdo_oe(mdo_oe), .mdi(mdi)
  );

  // PHY model: records each slot at mdc rise, feeds data only in read window
  always @(posedge mdc) begin
    if (slot_n < 128) begin
      rec_mdo[slot_n] = mdo;
      rec_oe[slot_n]  = mdo_oe;
    end
    if (slot_n >= 47 && slot_n <= 62) mdi = phy_word[15 - (slot_n - 47)];
    else                              mdi = 1'b1;
    slot_n = slot_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one transaction; optionally raises req_valid mid-frame
  task automatic run_frame(input logic wr, input logic [4:0] r,
                           input logic [15:0] wd, input bit poke,
                           output int lat, output int hi);
    int n;
    slot_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = r; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; hi = 0;
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 100) begin
        req_valid = 1'b1; req_write = ~wr; req_reg = ~r; req_wdata = ~wd;
      end
      if (poke && n == 106) req_valid = 1'b0;
      if (mdc) hi++;
      if (rsp_done) break;
    end
    lat = n;
    chk(rsp_done && req_ready, "R8 done with ready", {rsp_done, req_ready}, 2'b11);
    chk(!mdc && !mdo && !mdo_oe, "R9 link idle at done", {mdc, mdo, mdo_oe}, 0);
    @(negedge clk);
    chk(!rsp_done, "R8 done one cycle", rsp_done, 0);
  endtask

  task automatic check_header(input logic wr, input logic [4:0] r);
    int bad = 0;
    logic [9:0] addr_reg;
    for (int i = 0; i < 32; i++) if (!(rec_mdo[i] && rec_oe[i])) bad++;
    chk(bad == 0, "R2 preamble", bad, 0);
    chk({rec_mdo[32], rec_mdo[33], rec_mdo[34], rec_mdo[35]} == {2'b01, wr ? 2'b01 : 2'b10}
        && rec_oe[32] && rec_oe[33] && rec_oe[34] && rec_oe[35], "R3 start and op",
        {rec_mdo[32], rec_mdo[33], rec_mdo[34], rec_mdo[35]}, {2'b01, wr ? 2'b01 : 2'b10});
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      addr_reg[9 - i] = rec_mdo[36 + i];
      if (!rec_oe[36 + i]) bad++;
    end
    chk(addr_reg == {5'b0, r} && bad == 0, "R4 phy addr and reg", addr_reg, {5'b0, r});
    chk(slot_n == 64, "R7 slot count", slot_n, 64);
  endtask

  task automatic test_read(input logic [4:0] r, input logic [15:0] val, input bit poke);
    int lat, hi, bad;
    phy_word = val;
    run_frame(1'b0, r, 16'h0000, poke, lat, hi);
    check_header(1'b0, r);
    bad = 0;
    for (int i = 46; i < 64; i++) if (rec_oe[i] || rec_mdo[i]) bad++;
    chk(bad == 0, "R5 read released slots", bad, 0);
    chk(rsp_rdata == val, "R6 read data", rsp_rdata, val);
    chk(lat == 129 * HALF, "R8 latency", lat, 129 * HALF);
    chk(hi == 64 * HALF, "R13 high phase cycles", hi, 64 * HALF);
  endtask

  task automatic test_write(input logic [4:0] r, input logic [15:0] wd,
                            input logic [15:0] held);
    int lat, hi;
    logic [15:0] got;
    int bad = 0;
    phy_word = 16'hFFFF;
    run_frame(1'b1, r, wd, 1'b0, lat, hi);
    check_header(1'b1, r);
    chk(!rec_oe[46] && !rec_oe[47], "R10 two turnaround slots", {rec_oe[46], rec_oe[47]}, 0);
    for (int i = 0; i < 16; i++) begin
      got[15 - i] = rec_mdo[48 + i];
      if (!rec_oe[48 + i]) bad++;
    end
    chk(got == wd && bad == 0, "R10 write data", got, wd);
    chk(rsp_rdata == held, "R11 rdata held over write", rsp_rdata, held);
    chk(lat == 129 * HALF, "R8 write latency", lat, 129 * HALF);
  endtask

  task automatic test_busy_ignore();
    test_read(5'h0A, 16'h5A3C, 1'b1);
    slot_n = 0;
    repeat (40) @(negedge clk);
    chk(slot_n == 0 && req_ready, "R12 no extra frame", slot_n, 0);
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_reg = '0; req_wdata = '0; mdi = 1'b1; slot_n = 0; phy_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !mdc && !mdo && !mdo_oe && !rsp_done, "R1 reset state",
        {req_ready, mdc, mdo, mdo_oe, rsp_done}, 5'b10000);
    test_read(5'h11, 16'hA5C3, 1'b0);
    test_read(5'h1F, 16'h0001, 1'b0);
    test_write(5'h03, 16'h8421, 16'h0001);
    test_read(5'h00, 16'h8000, 1'b0);
    test_write(5'h15, 16'hFFFE, 16'h8000);
    test_busy_ignore();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule